// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Time Insertion

This core turns a pulse-width number into a pair of complementary drive signals for one leg of a switching bridge. A free-running period counter, advanced by a programmable clock prescaler, is compared against the pulse-width input. The comparison gives a raw PWM level. A dead-time stage turns that level into two outputs, `out1` and `out2`. After every change of the raw level, the dead-time stage holds both outputs low for a programmable number of clocks, so the two switches of a leg are never on together.

The counter runs with 8 bits (256 counts per period) or 7 bits (128 counts per period), which trades resolution against PWM frequency. The pulse-width input is one bit wider than the counter, so the duty cycle covers 0% to 100% in both modes. Every setting is a live input: a change of pulse width, dead time, mode or prescale is seen at the next clock edge, and does not wait for the period boundary. A one-clock `cyc_start` strobe marks each wrap of the counter to zero, for use by external protection logic. A global `out_en` forces both outputs low. A synchronous `clr` restarts the whole core.

Top module: `cpwm_dt`

## Requirements
- R1: The raw level is high while the period counter is below `pw`. With no dead time pending, `out1` equals the raw level and `out2` is its inverse. In steady state, `out1` is high for `pw`×div − 2×`dt_sel` clocks per period and `out2` is high for (P−`pw`)×div − 2×`dt_sel` clocks per period.
- R2: `out1` and `out2` are never high in the same cycle.
- R3: On every change of the raw level, both outputs are low for exactly 2×`dt_sel` clocks (0 to 14), starting at the edge that sees the change. After that, the newly active output goes high. A value of 0 switches the outputs at that same edge. A further raw change during the blanking restarts the interval.
- R4: `mode8`=1 gives a period of P=256 counter steps (counts 0 to 255). `mode8`=0 gives P=128 (counts 0 to 127). If the counter is above the short top when 7-bit mode is selected, it wraps to 0 on its next step.
- R5: `pre_sel` values 0, 1, 2 and 3 advance the counter once every 1, 2, 4 and 8 clocks. The period in clocks is therefore P×2^`pre_sel`.
- R6: With `pw`=0, `out1` never goes high. With `pw` ≥ P (up to 256), `out1` never goes low. While the raw level stays constant, no blanking occurs.
- R7: A new `pw` value acts on the outputs at the first rising clock edge after it is applied.
- R8: With `out_en`=0, both outputs are low from the next edge onward. The dead-time sequencing keeps running while the outputs are gated.
- R9: `cyc_start` is high for one clock, in the cycle in which the counter has just wrapped to 0. In steady state it pulses once per period.
- R10: `clr` sampled high at an edge makes `out1`, `out2` and `cyc_start` low and the counter 0 after that edge. The first `cyc_start` then comes P×div clocks later.
- R11: While `rst_n` is low, all outputs are low. After `rst_n` rises, the core stays in reset for two more clock edges, then starts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of counter, dead-time state and outputs |
| pw | input | 9 | Pulse width in counter steps, 0 to 256 |
| mode8 | input | 1 | 1: 8-bit period, 0: 7-bit period |
| dt_sel | input | 3 | Dead time, in units of two clocks |
| pre_sel | input | 2 | Counter prescale, divide by 2^pre_sel |
| out_en | input | 1 | 0 forces both outputs low |
| out1 | output | 1 | Main PWM output, high while the counter is below pw |
| out2 | output | 1 | Complementary PWM output |
| cyc_start | output | 1 | One-clock strobe at each counter wrap to zero |

## Verification
All three outputs are registered. Each reflects the inputs and the counter value present just before a rising edge, so a change to `pw`, `out_en` or `clr` shows at the ports one edge later. A dead-time interval started at edge k ends with the new output high after edge k+2×`dt_sel`. `cyc_start` appears in the cycle after the edge at which the counter passes its top value. The bench keeps a behavioural model that it advances at each rising edge, drives inputs only on falling edges, and compares all three outputs against the model at every falling edge. Directed windows of exactly one period also count the high clocks of each output and the `cyc_start` pulses. The two extra reset-release edges are part of the model.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic [1:0] {
    PRE_DIV1 = 2'd0,
    PRE_DIV2 = 2'd1,
    PRE_DIV4 = 2'd2,
    PRE_DIV8 = 2'd3
  } pre_div_e;

  // dead-time length in clocks: twice the programmed field
  function automatic logic [3:0] dt_clocks(input logic [2:0] field);
    return {field, 1'b0};
  endfunction

endpackage

// File: rtl/cpwm_prescale.sv
module cpwm_prescale #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0] div_q, div_d, lim;

  // limit = 2^sel - 1, built as a thermometer code
  always_comb begin
    lim = '0;
    for (int i = 0; i < PC_W; i++) begin
      lim[i] = (i < int'(sel));
    end
  end

  assign tick = (div_q >= lim);

  always_comb begin
    if (clr || tick) div_d = '0;
    else             div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/cpwm_period.sv
module cpwm_period #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             mode_full,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_q
);
  logic [CNT_W-1:0] cnt_d, top;
  logic             at_top, wrap_d;

  // short mode drops the counter's top bit
  generate
    if (CNT_W > 1) begin : g_two_modes
      assign top = mode_full ? {CNT_W{1'b1}} : {1'b0, {(CNT_W-1){1'b1}}};
    end else begin : g_one_mode
      assign top = {CNT_W{1'b1}};
    end
  endgenerate

  assign at_top = (cnt_q >= top);

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      if (at_top) begin
        cnt_d  = '0;
        wrap_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DT_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            raw,
  input  logic [DT_W-1:0] dt_sel,
  input  logic            en,
  output logic            out1,
  output logic            out2
);
  localparam int DC_W = DT_W + 1;

  logic            lvl_q, lvl_d;
  logic [DC_W-1:0] hold_q, hold_d, hold_len;
  logic            o1_d, o2_d;

  assign hold_len = {dt_sel, 1'b0};

  always_comb begin
    lvl_d  = lvl_q;
    hold_d = hold_q;
    if (clr) begin
      lvl_d  = 1'b0;
      hold_d = '0;
    end else if (raw != lvl_q) begin
      lvl_d  = raw;
      hold_d = hold_len;
    end else if (hold_q != '0) begin
      hold_d = hold_q - 1'b1;
    end
    o1_d = !clr && en && (hold_d == '0) &&  lvl_d;
    o2_d = !clr && en && (hold_d == '0) && !lvl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      hold_q <= '0;
      out1   <= 1'b0;
      out2   <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      hold_q <= hold_d;
      out1   <= o1_d;
      out2   <= o2_d;
    end
  end
endmodule

// File: rtl/cpwm_dt.sv
module cpwm_dt #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 3,
  parameter int PS_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W:0]   pw,
  input  logic             mode8,
  input  logic [DT_W-1:0]  dt_sel,
  input  logic [PS_W-1:0]  pre_sel,
  input  logic             out_en,
  output logic             out1,
  output logic             out2,
  output logic             cyc_start
);
  logic [1:0]       rst_sync;
  logic             rst_ni;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic             raw;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  cpwm_prescale #(.PS_W(PS_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_ni),
    .clr   (clr),
    .sel   (pre_sel),
    .tick  (tick)
  );

  cpwm_period #(.CNT_W(CNT_W)) u_per (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr       (clr),
    .tick      (tick),
    .mode_full (mode8),
    .cnt_q     (cnt_q),
    .wrap_q    (cyc_start)
  );

  // pw is one bit wider so that 100% duty is reachable
  assign raw = ({1'b0, cnt_q} < pw);

  cpwm_deadband #(.DT_W(DT_W)) u_db (
    .clk    (clk),
    .rst_n  (rst_ni),
    .clr    (clr),
    .raw    (raw),
    .dt_sel (dt_sel),
    .en     (out_en),
    .out1   (out1),
    .out2   (out2)
  );
endmodule

// File: rtl/cpwm_dt_chk.sv
module cpwm_dt_chk #(
  parameter int CNT_W = 8,
  parameter int DT_W  = 3
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             clr,
  input logic             out_en,
  input logic [DT_W-1:0]  dt_sel,
  input logic             out1,
  input logic             out2,
  input logic             cyc_start,
  input logic [CNT_W-1:0] cnt_q
);
  // R2: the two outputs are never on together
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !(out1 && out2));

  // R3: with a nonzero dead time, out1 cannot rise straight from out2 high
  p_gap_before_rise_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(out1) && ($past(dt_sel) != '0)) |-> $past(!out2));

  // R8: enable low forces both outputs low one edge later
  p_gate_off_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !out_en |=> (!out1 && !out2));

  // R9: the strobe lasts one clock and marks a counter at zero
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    cyc_start |=> !cyc_start);

  p_strobe_zero_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    cyc_start |-> (cnt_q == '0));

  // R10: synchronous clear empties outputs and counter
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (!out1 && !out2 && !cyc_start && (cnt_q == '0)));
endmodule

bind cpwm_dt cpwm_dt_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .clr       (clr),
  .out_en    (out_en),
  .dt_sel    (dt_sel),
  .out1      (out1),
  .out2      (out2),
  .cyc_start (cyc_start),
  .cnt_q     (cnt_q)
);

// File: tb/cpwm_dt_test.sv
`timescale 1ns/1ps
module cpwm_dt_test;
  logic       clk = 1'b0;
  logic       rst_n, clr, mode8, out_en;
  logic [8:0] pw;
  logic [2:0] dt_sel;
  logic [1:0] pre_sel;
  logic       out1, out2, cyc_start;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  cpwm_dt uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pw(pw), .mode8(mode8),
    .dt_sel(dt_sel), .pre_sel(pre_sel), .out_en(out_en),
    .out1(out1), .out2(out2), .cyc_start(cyc_start)
  );

  // behavioural reference, advanced at each rising edge
  int m_div, m_cnt, m_lvl, m_hold, m_rel;
  bit m_o1, m_o2, m_cs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_div = 0; m_cnt = 0; m_lvl = 0; m_hold = 0;
      m_o1 = 0; m_o2 = 0; m_cs = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else if (clr) begin
      m_div = 0; m_cnt = 0; m_lvl = 0; m_hold = 0;
      m_o1 = 0; m_o2 = 0; m_cs = 0;
    end else begin
      int top, raw;
      bit stp;
      top = mode8 ? 255 : 127;
      stp = (m_div >= (1 << pre_sel) - 1);
      raw = (m_cnt < int'(pw)) ? 1 : 0;
      if (raw != m_lvl) begin
        m_lvl  = raw;
        m_hold = 2 * int'(dt_sel);
      end else if (m_hold > 0) begin
        m_hold--;
      end
      m_o1 = out_en && (m_hold == 0) && (m_lvl == 1);
      m_o2 = out_en && (m_hold == 0) && (m_lvl == 0);
      m_cs = stp && (m_cnt >= top);
      if (stp) m_cnt = (m_cnt >= top) ? 0 : m_cnt + 1;
      m_div = stp ? 0 : m_div + 1;
    end
  end

  // every-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (out1 !== m_o1 || out2 !== m_o2) begin
        errors++;
        $display("FAIL R1 R3 cycle %0d out1/out2 got %b%b exp %b%b",
                 cycles, out1, out2, m_o1, m_o2);
      end
      checks++;
      if (cyc_start !== m_cs) begin
        errors++;
        $display("FAIL R9 cycle %0d cyc_start got %b exp %b",
                 cycles, cyc_start, m_cs);
      end
      checks++;
      if (out1 && out2) begin
        errors++;
        $display("FAIL R2 cycle %0d out1/out2 got 11 exp not 11", cycles);
      end
    end
  end

  task automatic summary();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got %0d cycles exp fewer", cycles);
      summary();
    end
  end

  task automatic check_val(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int n, output int h1, output int h2, output int st);
    h1 = 0; h2 = 0; st = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h1 += int'(out1);
      h2 += int'(out2);
      st += int'(cyc_start);
    end
  endtask

  initial begin
    int h1, h2, st, seed, k;
    rst_n = 0; clr = 0; pw = 9'd64; mode8 = 1; dt_sel = 3'd0;
    pre_sel = 2'd0; out_en = 1;
    wait_n(4);
    // R11: reset holds every output low
    check_val("R11 reset out1", int'(out1), 0);
    check_val("R11 reset out2", int'(out2), 0);
    check_val("R11 reset cyc_start", int'(cyc_start), 0);
    rst_n = 1;

    // R1 R4 R9: 8-bit, divide by 1, no dead time
    wait_n(600);
    measure(256, h1, h2, st);
    check_val("R1 out1 high clocks pw64", h1, 64);
    check_val("R1 out2 high clocks pw64", h2, 192);
    check_val("R9 strobes per 8-bit period", st, 1);

    // R3: dead time of 6 clocks
    dt_sel = 3'd3;
    wait_n(600);
    measure(256, h1, h2, st);
    check_val("R3 out1 high clocks dt6", h1, 58);
    check_val("R3 out2 high clocks dt6", h2, 186);

    // R4 R5: 7-bit, divide by 4, dead time 4
    mode8 = 0; pre_sel = 2'd2; pw = 9'd32; dt_sel = 3'd2;
    wait_n(1200);
    measure(512, h1, h2, st);
    check_val("R5 out1 high clocks 7-bit div4", h1, 124);
    check_val("R5 out2 high clocks 7-bit div4", h2, 380);
    check_val("R4 strobes per 7-bit div4 period", st, 1);

    // R5: divide by 8, 8-bit period of 2048 clocks
    mode8 = 1; pre_sel = 2'd3; dt_sel = 3'd7; pw = 9'd100;
    wait_n(4200);
    measure(2048, h1, h2, st);
    check_val("R5 out1 high clocks div8 dt14", h1, 786);
    check_val("R4 strobes per div8 period", st, 1);

    // R6: 0% and 100%
    pre_sel = 2'd0; dt_sel = 3'd1; pw = 9'd0;
    wait_n(600);
    measure(256, h1, h2, st);
    check_val("R6 pw0 out1 clocks", h1, 0);
    check_val("R6 pw0 out2 clocks", h2, 256);
    pw = 9'd256;
    wait_n(600);
    measure(256, h1, h2, st);
    check_val("R6 pw256 out1 clocks", h1, 256);
    check_val("R6 pw256 out2 clocks", h2, 0);

    // R7: new pw acts at the next edge
    dt_sel = 3'd0;
    wait_n(4);
    pw = 9'd0;
    @(negedge clk);
    check_val("R7 out1 one edge after pw write", int'(out1), 0);
    check_val("R7 out2 one edge after pw write", int'(out2), 1);

    // R8: gating off
    pw = 9'd128;
    wait_n(300);
    out_en = 0;
    @(negedge clk);
    check_val("R8 out1 gated", int'(out1), 0);
    check_val("R8 out2 gated", int'(out2), 0);
    measure(256, h1, h2, st);
    check_val("R8 out1 clocks while gated", h1, 0);
    check_val("R8 out2 clocks while gated", h2, 0);
    out_en = 1;

    // R10: synchronous clear restarts the period
    wait_n(300);
    clr = 1;
    @(negedge clk);
    clr = 0;
    check_val("R10 out1 after clr", int'(out1), 0);
    check_val("R10 cyc_start after clr", int'(cyc_start), 0);
    k = 0;
    while (!cyc_start && k < 1000) begin
      @(negedge clk);
      k++;
    end
    check_val("R10 clocks from clr to first strobe", k, 256);

    // R2 R3 R7: irregular pw and dead-time changes, model compare
    seed = 12345;
    for (int i = 0; i < 600; i++) begin
      seed = seed * 1103515245 + 12345;
      pw     = 9'((seed >>> 8) % 257);
      dt_sel = 3'((seed >>> 20) & 7);
      out_en = ((seed >>> 24) & 15) != 0;
      if (i % 150 == 0) pre_sel = 2'((seed >>> 4) & 3);
      if (i % 200 == 100) mode8 = ~mode8;
      wait_n(1 + ((seed >>> 16) & 7));
    end

    // R11: asynchronous reset mid-run
    rst_n = 0;
    #1;
    check_val("R11 out1 during async reset", int'(out1), 0);
    check_val("R11 out2 during async reset", int'(out2), 0);
    wait_n(3);
    summary();
  end
endmodule